// File: doc/BRIEF.md
# Synchronous FIFO with Retransmit

A single-clock first-in first-out buffer for 9-bit words with a small, parameterised depth. A producer pushes words with a write enable and a consumer pops them with a read enable. The block reports five status flags: empty, full, half-full, almost-empty and almost-full. The two almost thresholds come from offset registers that are loaded from a shared offset input.

A retransmit pulse returns the read side to storage location zero and keeps every stored word. The consumer can then read the packet again from its first word. Words written after the pulse follow the replayed words. While the pulse is high, and for a parameterised number of cycles after it, both enables are ignored.

Retransmit is only defined after at least one read since reset, and while the number of writes since reset is no more than the depth.

Top module: `fifo_rt`

## Requirements
- R1: While rst_ni is low, and after it is released, empty_o=1, full_o=0, half_o=0, aempty_o=1, afull_o=0 and rd_data_o=0. Both almost offsets hold DEPTH/8.
- R2: Words are read in the order they were written. An accepted read puts its word on rd_data_o on the clock edge that accepts it, so the word is visible in the following cycle. rd_data_o holds its value when no read is accepted.
- R3: A write while full and a read while empty are ignored and change neither the stored word count nor rd_data_o. A write together with a read on a full FIFO accepts only the read.
- R4: empty_o is 1 exactly when the stored word count is 0. full_o is 1 exactly when the count equals DEPTH.
- R5: half_o is 1 exactly when the count is greater than DEPTH/2.
- R6: ae_ld_i loads offset_i into the almost-empty offset, and af_ld_i loads offset_i into the almost-full offset; each load takes effect on the next edge. aempty_o = (count <= almost-empty offset). afull_o = (count + almost-full offset >= DEPTH).
- R7: On an edge where retx_i is 1, the read position returns to location 0 and the count becomes the number of writes since reset. All flags reflect the new count in the next cycle.
- R8: After a retransmit, reads return the words from the first word written since reset, in order, until the FIFO reports empty.
- R9: Words written after a retransmit are read after all replayed words.
- R10: rd_en_i and wr_en_i are ignored on the retx_i edge and for RECOVER edges after it.
- R11: A full-depth packet can be retransmitted, and retransmit can be repeated any number of times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both the write and the read side |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | WIDTH | Word to write |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | WIDTH | Registered read word |
| retx_i | input | 1 | Retransmit pulse |
| ae_ld_i | input | 1 | Load the almost-empty offset |
| af_ld_i | input | 1 | Load the almost-full offset |
| offset_i | input | $clog2(DEPTH+1) | Value for an offset load |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | DEPTH words stored |
| half_o | output | 1 | More than half full |
| aempty_o | output | 1 | At or below the almost-empty threshold |
| afull_o | output | 1 | Within the almost-full offset of full |

## Verification
A wrong count shows on the flags in the very next cycle, because every flag is decoded from the registered count. The bench therefore compares all five flags after every edge against a count it computes itself. A wrong read position or a corrupted storage word shows on rd_data_o one cycle after the affected read. After a retransmit, it shows on the first replayed word. A write or read that slips through the recovery window shows up later, either as an extra replayed word or as a skipped one, and as empty being reached at the wrong time.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
    logic aempty;
    logic afull;
  } flags_t;
endpackage

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
  parameter int DEPTH   = 16,
  parameter int RECOVER = 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          retx_i,
  output logic          wr_go_o,
  output logic          rd_go_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o
);
  localparam int HW = $clog2(RECOVER + 2);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, wr_tot_q;
  logic          blocked;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    if (RECOVER > 0) begin : g_hold
      logic [HW-1:0] hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             hold_q <= '0;
        else if (retx_i)         hold_q <= HW'(RECOVER);
        else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
      end
      assign blocked = retx_i | (hold_q != '0);
    end else begin : g_nohold
      assign blocked = retx_i;
    end
  endgenerate

  assign wr_go_o = wr_en_i && !blocked && (count_q != CW'(DEPTH));
  assign rd_go_o = rd_en_i && !blocked && (count_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      wr_tot_q <= '0;
    end else if (retx_i) begin
      rd_ptr_q <= '0;
      count_q  <= wr_tot_q;
    end else begin
      if (wr_go_o) wr_ptr_q <= bump(wr_ptr_q);
      if (rd_go_o) rd_ptr_q <= bump(rd_ptr_q);
      if (wr_go_o && wr_tot_q != CW'(DEPTH)) wr_tot_q <= wr_tot_q + 1'b1;
      case ({wr_go_o, rd_go_o})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign count_o  = count_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  p_full_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CW'(DEPTH) && !rd_en_i && !retx_i) |=> count_q == CW'(DEPTH));
  p_retx_rewind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retx_i |=> (rd_ptr_q == '0 && count_q == $past(wr_tot_q)));
  p_retx_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retx_i |=> ($stable(wr_ptr_q) && $stable(wr_tot_q)));
endmodule

// File: rtl/fifo_rt_store.sv
module fifo_rt_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_go_i,
  input  logic [AW-1:0]    wr_ptr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_go_i,
  input  logic [AW-1:0]    rd_ptr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_go_i) mem_q[wr_ptr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_go_i) rd_data_o <= mem_q[rd_ptr_i];
  end

  p_rd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_go_i |=> $stable(rd_data_o));
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic          ae_ld_i,
  input  logic          af_ld_i,
  input  logic [CW-1:0] offset_i,
  output flags_t        flags_o
);
  logic [CW-1:0] ae_off_q, af_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_off_q <= CW'(DEPTH / 8);
      af_off_q <= CW'(DEPTH / 8);
    end else begin
      if (ae_ld_i) ae_off_q <= offset_i;
      if (af_ld_i) af_off_q <= offset_i;
    end
  end

  always_comb begin
    flags_o.empty  = (count_i == '0);
    flags_o.full   = (count_i == CW'(DEPTH));
    flags_o.half   = (count_i > CW'(DEPTH / 2));
    flags_o.aempty = (count_i <= ae_off_q);
    flags_o.afull  = ({1'b0, count_i} + {1'b0, af_off_q}) >= (CW + 1)'(DEPTH);
  end

  p_empty_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_o.empty && flags_o.full));
  p_full_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.full |-> flags_o.half);
  p_ae_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ae_ld_i |=> ae_off_q == $past(offset_i));
  p_af_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    af_ld_i |=> af_off_q == $past(offset_i));
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int WIDTH   = 9,
  parameter int DEPTH   = 16,
  parameter int RECOVER = 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             retx_i,
  input  logic             ae_ld_i,
  input  logic             af_ld_i,
  input  logic [CW-1:0]    offset_i,
  output logic             empty_o,
  output logic             full_o,
  output logic             half_o,
  output logic             aempty_o,
  output logic             afull_o
);
  logic          wr_go, rd_go;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  flags_t        flags;

  fifo_rt_ctrl #(.DEPTH(DEPTH), .RECOVER(RECOVER)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .retx_i,
    .wr_go_o(wr_go), .rd_go_o(rd_go), .wr_ptr_o(wr_ptr),
    .rd_ptr_o(rd_ptr), .count_o(count)
  );

  fifo_rt_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .wr_go_i(wr_go), .wr_ptr_i(wr_ptr), .wr_data_i,
    .rd_go_i(rd_go), .rd_ptr_i(rd_ptr), .rd_data_o
  );

  fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i, .rst_ni, .count_i(count), .ae_ld_i, .af_ld_i, .offset_i,
    .flags_o(flags)
  );

  assign empty_o  = flags.empty;
  assign full_o   = flags.full;
  assign half_o   = flags.half;
  assign aempty_o = flags.aempty;
  assign afull_o  = flags.afull;

  p_empty_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> $stable(rd_data_o));
endmodule

// File: tb/fifo_rt_tb.sv
module fifo_rt_tb;
  localparam int CLK = 10;
  localparam int D   = 8;
  localparam int REC = 1;
  localparam int CW  = $clog2(D + 1);

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, rd_en = 0, retx = 0, ae_ld = 0, af_ld = 0;
  logic [8:0] wd = '0;
  logic [CW-1:0] offv = '0;
  logic [8:0] rd_data;
  logic empty, full, half, aempty, afull;

  int n_chk = 0, n_fail = 0;
  int hist[64];
  int wtot, ridx, aeo, afo, last, seed;

  always #(CLK / 2) clk = ~clk;

  fifo_rt #(.WIDTH(9), .DEPTH(D), .RECOVER(REC)) u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_data_i(wd), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .retx_i(retx), .ae_ld_i(ae_ld), .af_ld_i(af_ld),
    .offset_i(offv), .empty_o(empty), .full_o(full), .half_o(half),
    .aempty_o(aempty), .afull_o(afull)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic flags_chk(input string req);
    int c = wtot - ridx;
    chk(empty == (c == 0), {req, " empty R4"}, empty, c == 0);
    chk(full == (c == D), {req, " full R4"}, full, c == D);
    chk(half == (c > D / 2), {req, " half R5"}, half, c > D / 2);
    chk(aempty == (c <= aeo), {req, " aempty R6"}, aempty, c <= aeo);
    chk(afull == (c + afo >= D), {req, " afull R6"}, afull, c + afo >= D);
  endtask

  function automatic int word(input int k);
    return (k * 37 + 5 + seed * 11) & 'h1ff;
  endfunction

  task automatic do_reset();
    rst_ni = 0; wr_en = 0; rd_en = 0; retx = 0; ae_ld = 0; af_ld = 0;
    #(CLK * 2);
    chk(empty && !full && !half && aempty && !afull && rd_data == 0,
        "R1 flags in reset", {empty, full, half, aempty, afull}, 5'b10010);
    @(posedge clk); #1;
    rst_ni = 1;
    wtot = 0; ridx = 0; aeo = D / 8; afo = D / 8; last = 0; seed++;
    flags_chk("R1 after reset");
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
  endtask

  // one cycle with optional write and read; model applied after the edge
  task automatic cyc(input bit w, input bit r, input string req);
    int c = wtot - ridx;
    bit acc_r = r && c > 0;
    bit acc_w = w && c < D;
    wr_en = w; rd_en = r; wd = 9'(word(wtot));
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
    if (acc_r) begin
      chk(rd_data == 9'(hist[ridx % 64]), {req, " read order R2"}, rd_data, hist[ridx % 64]);
      last = hist[ridx % 64];
      ridx++;
    end else begin
      chk(rd_data == 9'(last), {req, " hold R2 R3"}, rd_data, last);
    end
    if (acc_w) begin
      hist[wtot % 64] = word(wtot);
      wtot++;
    end
    flags_chk(req);
  endtask

  task automatic load_off(input bit ae, input int v);
    offv = CW'(v); ae_ld = ae; af_ld = !ae;
    @(posedge clk); #1;
    ae_ld = 0; af_ld = 0;
    if (ae) aeo = v; else afo = v;
    flags_chk("R6 load");
  endtask

  // retransmit pulse with enables optionally held through the recovery window
  task automatic retx_pulse(input bit w, input bit r);
    retx = 1; wr_en = w; rd_en = r; wd = 9'h1aa;
    @(posedge clk); #1;
    retx = 0;
    ridx = 0;
    flags_chk("R7 retx");
    chk(rd_data == 9'(last), "R10 rd_data on retx edge", rd_data, last);
    for (int i = 0; i < REC; i++) begin
      @(posedge clk); #1;
      chk(rd_data == 9'(last), "R10 recovery read ignored", rd_data, last);
      flags_chk("R10 recovery");
    end
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #(CLK * 150000);
    n_fail++;
    $display("FAIL watchdog expired R1 act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    seed = 0;
    do_reset();
    // fill past full, drain past empty
    for (int i = 0; i < D + 2; i++) cyc(1, 0, "R3 fill");
    for (int i = 0; i < D + 2; i++) cyc(0, 1, "R3 drain");
    // mixed traffic with simultaneous enables
    for (int i = 0; i < 60; i++) cyc(i % 3 != 0, i % 2 == 0, "R2 mixed");
    for (int i = 0; i < D; i++) cyc(1, 0, "R3 refill");
    cyc(1, 1, "R3 full read+write");
    // offset sweep
    for (int o = 0; o <= D; o++) begin
      do_reset();
      load_off(1, o);
      load_off(0, D - o);
      for (int i = 0; i < D; i++) cyc(1, 0, "R6 sweep fill");
      for (int i = 0; i < D; i++) cyc(0, 1, "R6 sweep drain");
    end
    // partial retransmit with blocked enables, then new writes
    do_reset();
    for (int i = 0; i < 5; i++) cyc(1, 0, "R7 load");
    for (int i = 0; i < 3; i++) cyc(0, 1, "R7 first read");
    retx_pulse(1, 1);
    cyc(1, 0, "R9 write after retx");
    cyc(1, 0, "R9 write after retx");
    for (int i = 0; i < 8; i++) cyc(0, 1, "R8 R9 replay");
    chk(empty, "R8 empty after replay", empty, 1);
    // full-depth, repeated retransmit
    do_reset();
    for (int i = 0; i < D; i++) cyc(1, 0, "R11 fill");
    for (int i = 0; i < D; i++) cyc(0, 1, "R11 read");
    retx_pulse(0, 0);
    chk(full, "R11 full after retx", full, 1);
    for (int i = 0; i < D; i++) cyc(0, 1, "R11 replay1");
    retx_pulse(0, 0);
    for (int i = 0; i < D / 2; i++) cyc(0, 1, "R11 replay2");
    retx_pulse(1, 0);
    for (int i = 0; i < D + 1; i++) cyc(0, 1, "R11 replay3");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule